// File: doc/BRIEF.md
# Deduplicated Trip Record Queue

This block keeps an ordered log of process channels that have tripped. Each channel number, in the range 0 to 95, goes into the log the first time it trips after a clear. Later trips of the same channel are filtered out by a per-channel seen mask, so the log never holds more than one entry per channel. A sticky status bit reports whether any trip has happened since the last clear.

The host reads the log oldest-first with a one-cycle read strobe. Reading leaves the log unchanged. A context-change pulse rewinds the read position to the oldest entry, so the host can replay the whole list. Once every entry has been read, further strobes are refused. The exception is the first read after a rewind or a clear, which is always acknowledged. If the log is empty, that read returns an all-ones empty code. Either of two clear inputs, one from module reset and one from the system-reset event, empties the log, the mask and the status bit.

Top module: `trq_trip_log`

## Requirements
- R1: After reset, `trip_seen` and `rd_ack` are 0, and the first read strobe is acknowledged with `rd_data` = 16'hFFFF (the empty code).
- R2: A trip with `trip_chan` in 0..95 is appended to the log. Reads return entries in first-trip order, each as the channel number zero-extended to 16 bits.
- R3: A channel already in the log is not appended again when it trips again. With all 96 channels logged, the log holds exactly 96 entries.
- R4: A trip with `trip_chan` of 96 or more is ignored: nothing is logged and `trip_seen` does not change.
- R5: `rd_ack` and `rd_data` are valid in the cycle after the strobe. Once all entries have been read, a strobe that is not the first in its context gives `rd_ack` = 0.
- R6: The first read strobe after a rewind or a clear is always acknowledged. It returns the oldest entry, or 16'hFFFF when the log is empty.
- R7: A `ctx_change` pulse rewinds reading to the oldest entry, and the full list can be read again.
- R8: Reading does not remove entries or forget channels. A channel that has been read back is still not re-logged when it trips again.
- R9: A pulse on `clr_module` or on `clr_sysevt` empties the log, clears `trip_seen` and the seen mask, and rewinds reading. A channel can be logged again after a clear.
- R10: `trip_seen` rises in the cycle after any in-range trip, including a repeated one. It stays set until a clear.
- R11: A clear takes priority over a trip in the same cycle. A clear or a `ctx_change` in the same cycle as a read strobe suppresses that read (`rd_ack` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_valid | input | 1 | Trip event strobe |
| trip_chan | input | 7 | Channel number of the trip event |
| rd_strobe | input | 1 | Host read request, one cycle |
| rd_data | output | 16 | Logged channel number, or 16'hFFFF when empty |
| rd_ack | output | 1 | Read accepted, one cycle after the strobe |
| ctx_change | input | 1 | Rewind reading to the oldest entry |
| clr_module | input | 1 | Clear from module reset |
| clr_sysevt | input | 1 | Clear from the system-reset event |
| trip_seen | output | 1 | Sticky: a trip occurred since the last clear |

## Verification
Corrupted internal state shows up at the read port. A seen mask that is wrong either repeats a channel or drops a first trip, and the replay after a rewind reveals this within one pass through the list. A write position or entry count that is wrong shifts or truncates the list. The result is a wrong value on the next acknowledged read, or an acknowledge or refusal one strobe early or late. A read pointer that does not rewind returns a later entry on the very first read of the new context. All of these appear in the cycle after the offending strobe.

// File: rtl/trq_pkg.sv
package trq_pkg;

  // Outcome of one cycle at the read port.
  typedef enum logic [1:0] {
    RK_IDLE   = 2'd0,
    RK_ENTRY  = 2'd1,
    RK_EMPTY  = 2'd2,
    RK_REFUSE = 2'd3
  } rd_kind_e;

  // True when a channel number addresses a real channel.
  function automatic logic chan_ok(input int unsigned ch, input int unsigned n_ch);
    return ch < n_ch;
  endfunction

  // Decide what a read strobe does this cycle.
  function automatic rd_kind_e classify_read(input logic strobe, input logic blocked,
                                             input logic fresh, input logic have_entry);
    if (!strobe || blocked) return RK_IDLE;
    if (have_entry)         return RK_ENTRY;
    if (fresh)              return RK_EMPTY;
    return RK_REFUSE;
  endfunction

  // Zero-extend a channel number to the read-port width.
  function automatic logic [31:0] widen_chan(input logic [31:0] ch);
    return ch;
  endfunction

endpackage

// File: rtl/trq_dedup_filter.sv
module trq_dedup_filter #(
  parameter int NUM_CH = 96,
  parameter int CH_W   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            trip_valid,
  input  logic [CH_W-1:0] trip_chan,
  output logic            append_pulse,
  output logic [CH_W-1:0] append_chan,
  output logic            any_trip
);
  import trq_pkg::*;

  logic [NUM_CH-1:0] seen_q;
  logic              in_range;
  logic              already;

  assign in_range     = chan_ok(32'(trip_chan), NUM_CH);
  assign already      = in_range ? seen_q[trip_chan] : 1'b1;
  assign any_trip     = trip_valid && in_range && !clr;
  assign append_pulse = any_trip && !already;
  assign append_chan  = trip_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_q <= '0;
    else if (clr)          seen_q <= '0;
    else if (append_pulse) seen_q[trip_chan] <= 1'b1;
  end

endmodule

// File: rtl/trq_entry_store.sv
module trq_entry_store #(
  parameter int NUM_CH = 96,
  parameter int CH_W   = 7,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [CH_W-1:0]  rd_chan,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_CH);

  logic [CH_W-1:0]  mem_q [NUM_CH];
  logic [CNT_W-1:0] count_q;
  logic             has_room;

  assign has_room = count_q < CNT_MAX;
  assign count    = count_q;
  assign rd_chan  = (rd_idx < CNT_MAX) ? mem_q[rd_idx] : '0;

  always_ff @(posedge clk) begin
    if (wr_en && has_room) mem_q[count_q] <= wr_chan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count_q <= '0;
    else if (clr)               count_q <= '0;
    else if (wr_en && has_room) count_q <= count_q + 1'b1;
  end

endmodule

// File: rtl/trq_read_ctrl.sv
module trq_read_ctrl #(
  parameter int CH_W   = 7,
  parameter int CNT_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ctx_change,
  input  logic              rd_strobe,
  input  logic [CNT_W-1:0]  count,
  input  logic [CH_W-1:0]   entry_chan,
  output logic [CNT_W-1:0]  rd_idx,
  output logic              fresh,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data
);
  import trq_pkg::*;

  localparam logic [DATA_W-1:0] EMPTY_CODE = {DATA_W{1'b1}};

  logic [CNT_W-1:0]  idx_q;
  logic              fresh_q;
  logic              ack_q;
  logic [DATA_W-1:0] data_q;
  logic              have_entry;
  rd_kind_e          kind;

  assign have_entry = idx_q < count;
  assign kind       = classify_read(rd_strobe, clr || ctx_change, fresh_q, have_entry);
  assign rd_idx     = idx_q;
  assign fresh      = fresh_q;
  assign rd_ack     = ack_q;
  assign rd_data    = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      fresh_q <= 1'b1;
      ack_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      ack_q <= (kind == RK_ENTRY) || (kind == RK_EMPTY);
      if (clr || ctx_change) begin
        idx_q   <= '0;
        fresh_q <= 1'b1;
      end else begin
        case (kind)
          RK_ENTRY: begin
            data_q  <= DATA_W'(widen_chan(32'(entry_chan)));
            idx_q   <= idx_q + 1'b1;
            fresh_q <= 1'b0;
          end
          RK_EMPTY: begin
            data_q  <= EMPTY_CODE;
            fresh_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/trq_trip_log.sv
module trq_trip_log #(
  parameter int NUM_CH = 96,
  parameter int CH_W   = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip_valid,
  input  logic [CH_W-1:0]   trip_chan,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack,
  input  logic              ctx_change,
  input  logic              clr_module,
  input  logic              clr_sysevt,
  output logic              trip_seen
);
  localparam int CNT_W = $clog2(NUM_CH + 1);

  logic             clr;
  logic             append_pulse;
  logic [CH_W-1:0]  append_chan;
  logic             any_trip;
  logic [CNT_W-1:0] log_count;
  logic [CNT_W-1:0] rd_idx;
  logic [CH_W-1:0]  entry_chan;
  logic             fresh;
  logic             seen_q;

  assign clr       = clr_module || clr_sysevt;
  assign trip_seen = seen_q;

  trq_dedup_filter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .trip_valid(trip_valid), .trip_chan(trip_chan),
    .append_pulse(append_pulse), .append_chan(append_chan), .any_trip(any_trip)
  );

  trq_entry_store #(.NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(append_pulse), .wr_chan(append_chan),
    .rd_idx(rd_idx), .rd_chan(entry_chan), .count(log_count)
  );

  trq_read_ctrl #(.CH_W(CH_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_read (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ctx_change(ctx_change),
    .rd_strobe(rd_strobe), .count(log_count), .entry_chan(entry_chan),
    .rd_idx(rd_idx), .fresh(fresh), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (clr)      seen_q <= 1'b0;
    else if (any_trip) seen_q <= 1'b1;
  end

endmodule

// File: rtl/trq_trip_log_chk.sv
module trq_trip_log_chk #(
  parameter int NUM_CH = 96,
  parameter int CH_W   = 7,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trip_valid,
  input logic [CH_W-1:0]  trip_chan,
  input logic             rd_strobe,
  input logic             rd_ack,
  input logic             ctx_change,
  input logic             clr_module,
  input logic             clr_sysevt,
  input logic             trip_seen,
  input logic             append_pulse,
  input logic [CNT_W-1:0] log_count,
  input logic [CNT_W-1:0] rd_idx,
  input logic             fresh
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_CH);

  // R5: an acknowledge always answers a strobe one cycle earlier
  a_r5_ack_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(rd_strobe));

  // R5: a non-first strobe past the last entry is refused
  a_r5_refuse_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !fresh && rd_idx == log_count) |=> !rd_ack);

  // R3: each append grows the log by exactly one
  a_r3_append_counts_one: assert property (@(posedge clk) disable iff (!rst_n)
    append_pulse |=> log_count == $past(log_count) + 1'b1);

  // R4: out-of-range channels never append
  a_r4_range_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_valid && 32'(trip_chan) >= NUM_CH) |-> !append_pulse);

  // R9: a clear empties the log and the status bit
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_module || clr_sysevt) |=> (log_count == '0 && !trip_seen && rd_idx == '0));

  // R10: the status bit is sticky until a clear
  a_r10_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_seen && !clr_module && !clr_sysevt) |=> trip_seen);

  // R7: a context change rewinds reading
  a_r7_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_change && !clr_module && !clr_sysevt) |=> (rd_idx == '0 && fresh));

  // R3, R5: pointers stay within bounds
  always_ff @(posedge clk) begin
    if (rst_n) begin
      a_r3_count_bound: assert (log_count <= CNT_MAX);
      a_r5_idx_bound:   assert (rd_idx <= log_count);
    end
  end

endmodule

bind trq_trip_log trq_trip_log_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trip_valid(trip_valid), .trip_chan(trip_chan),
  .rd_strobe(rd_strobe), .rd_ack(rd_ack), .ctx_change(ctx_change),
  .clr_module(clr_module), .clr_sysevt(clr_sysevt), .trip_seen(trip_seen),
  .append_pulse(append_pulse), .log_count(log_count), .rd_idx(rd_idx), .fresh(fresh)
);

// File: tb/test_trq_trip_log.sv
`timescale 1ns/1ps
module test_trq_trip_log;
  localparam int NUM_CH = 96;
  localparam logic [15:0] EMPTY = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trip_valid = 1'b0;
  logic [6:0]  trip_chan = '0;
  logic        rd_strobe = 1'b0;
  logic        ctx_change = 1'b0;
  logic        clr_module = 1'b0;
  logic        clr_sysevt = 1'b0;
  logic [15:0] rd_data;
  logic        rd_ack;
  logic        trip_seen;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  trq_trip_log i_trq_trip_log (
    .clk(clk), .rst_n(rst_n), .trip_valid(trip_valid), .trip_chan(trip_chan),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_ack(rd_ack),
    .ctx_change(ctx_change), .clr_module(clr_module), .clr_sysevt(clr_sysevt),
    .trip_seen(trip_seen)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic trip(input int ch);
    trip_valid = 1'b1; trip_chan = 7'(ch);
    @(negedge clk);
    trip_valid = 1'b0;
  endtask

  task automatic rewind();
    ctx_change = 1'b1;
    @(negedge clk);
    ctx_change = 1'b0;
  endtask

  // Read expecting an acknowledged value.
  task automatic read_exp(input string req, input logic [15:0] exp);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check({req, " ack"}, rd_ack, 1);
    check({req, " data"}, rd_data, exp);
  endtask

  task automatic read_refused(input string req);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check({req, " refused"}, rd_ack, 0);
  endtask

  task automatic t_reset_state();
    check("R1 trip_seen", trip_seen, 0);
    check("R1 rd_ack", rd_ack, 0);
    read_exp("R1 R6 empty first read", EMPTY);
    read_refused("R5 second read empty");
  endtask

  task automatic t_order();
    trip(5); trip(90); trip(0); trip(95);
    check("R10 status set", trip_seen, 1);
    rewind();
    read_exp("R2 R6 first", 16'd5);
    read_exp("R2 second", 16'd90);
    read_exp("R2 third", 16'd0);
    read_exp("R2 fourth", 16'd95);
    read_refused("R5 drained");
  endtask

  task automatic t_duplicates();
    trip(90); trip(5); trip(40); trip(40);
    check("R10 status held", trip_seen, 1);
    rewind();
    read_exp("R3 e0", 16'd5);
    read_exp("R3 e1", 16'd90);
    read_exp("R3 e2", 16'd0);
    read_exp("R3 e3", 16'd95);
    read_exp("R3 e4", 16'd40);
    read_refused("R3 no duplicates");
  endtask

  task automatic t_out_of_range();
    clr_sysevt = 1'b1; idle(); clr_sysevt = 1'b0;
    check("R9 sysevt clears status", trip_seen, 0);
    read_exp("R9 R6 empty after clear", EMPTY);
    trip(96); trip(127);
    check("R4 status untouched", trip_seen, 0);
    rewind();
    read_exp("R4 still empty", EMPTY);
    read_refused("R4 nothing logged");
  endtask

  task automatic t_replay();
    trip(7); trip(8);
    rewind();
    read_exp("R7 partial", 16'd7);
    rewind();
    read_exp("R7 replay 0", 16'd7);
    read_exp("R7 replay 1", 16'd8);
    read_refused("R7 replay end");
    trip(7);
    check("R10 repeat trip keeps status", trip_seen, 1);
    rewind();
    read_exp("R8 kept 0", 16'd7);
    read_exp("R8 kept 1", 16'd8);
    read_refused("R8 no re-log after read");
  endtask

  task automatic t_module_clear();
    clr_module = 1'b1; idle(); clr_module = 1'b0;
    check("R9 module clears status", trip_seen, 0);
    trip(8);
    read_exp("R9 relog after clear", 16'd8);
    read_refused("R9 single entry");
  endtask

  task automatic t_priority();
    clr_module = 1'b1; trip_valid = 1'b1; trip_chan = 7'd3;
    idle();
    clr_module = 1'b0; trip_valid = 1'b0;
    check("R11 clear beats trip status", trip_seen, 0);
    read_exp("R11 clear beats trip log", EMPTY);
    trip(9);
    ctx_change = 1'b1; rd_strobe = 1'b1;
    idle();
    ctx_change = 1'b0; rd_strobe = 1'b0;
    check("R11 ctx suppresses read", rd_ack, 0);
    read_exp("R11 after suppressed read", 16'd9);
    clr_sysevt = 1'b1; rd_strobe = 1'b1;
    idle();
    clr_sysevt = 1'b0; rd_strobe = 1'b0;
    check("R11 clear suppresses read", rd_ack, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < NUM_CH; i++) trip(NUM_CH - 1 - i);
    trip(0); trip(50);
    rewind();
    for (int i = 0; i < NUM_CH; i++) read_exp("R2 R3 full order", 16'(NUM_CH - 1 - i));
    read_refused("R3 full has 96 entries");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset_state();
    t_order();
    t_duplicates();
    t_out_of_range();
    t_replay();
    t_module_clear();
    t_priority();
    t_full();
    repeat (2) idle();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule